// File: doc/BRIEF.md
# NAND Controller Configuration and Interrupt Register Block

This block is the software-visible register file of a NAND flash controller. It holds the interface configuration and the bus timing word, both of which steer the rest of the controller. It also holds the interrupt mask, the latched interrupt events, a read-only snapshot of the core's live status, a chip-enable mode bit and a command port that can reset the controller core. Software reaches it through a plain register bus. Each access is a one-cycle strobe with a word address, 32-bit write data and four byte-lane enables. Read data appears in the cycle after the read strobe and holds until the next read. No access can be back-pressured.

The configuration and timing registers are guarded by a one-shot key. Writing the 16-bit key `0xA25E` to the key register opens the guard for exactly one write to either guarded register. The guard closes again after that write. Event pulses from the controller core are accumulated in a sticky status register. That register empties when software reads it. A single active-high interrupt line reports any event that is both latched and enabled in the mask.

Word addresses: 0 command, 1 key, 2 configuration, 3 timing, 4 interrupt mask, 5 interrupt status, 6 live status, 7 chip-enable mode. All other addresses read as zero and ignore writes.

Top module: `nand_regblk`

## Requirements
- R1: After reset, the configuration, timing, mask, interrupt status and chip-enable outputs are all zero, `irq_o` is low, and the guard is closed.
- R2: A write of `0xA25E` to the key register (address 1, with both lanes 0 and 1 enabled) opens the guard for exactly one write to address 2 or 3. That write takes effect, and the guard closes in the same cycle.
- R3: A write to address 2 or 3 while the guard is closed is ignored, and the register keeps its value.
- R4: A write to any address other than 1, 2 or 3 leaves the guard state unchanged. A write to address 1 with any other value closes the guard.
- R5: An event pulse on `evt_i` sets the matching status bit, and the bit stays set until it is cleared. Bit layout of mask and status: 5 NAND ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault.
- R6: A read of address 5 returns the latched events and clears them. An event that arrives in the same cycle as that read stays latched.
- R7: `irq_o` is high exactly when some status bit and its mask bit are both set.
- R8: A write of `0xFF` in lane 0 to address 0 raises `core_reset_o` for one cycle, starting in the cycle after the write. Any other value gives no pulse.
- R9: Address 6 reads the live core status: bit 0 NAND ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bits 5:4 corrected symbols minus one, bit 6 decoder failure.
- R10: Configuration bits drive `cfg_o`: bit 3 write-protect enable, bit 2 large-block device, bit 1 five-byte addressing, bit 0 16-bit bus. Bit 0 of address 7 drives `ce_normal_o`, where 1 means the controller drives chip enable.
- R11: Byte-lane enables select which bytes of a write are stored. Unselected bytes keep their value.
- R12: Read data appears in the cycle after `rd_en`. An unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte-lane enables |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| evt_i | input | 6 | Event pulses from the controller core |
| nand_rdy_i | input | 1 | Live NAND ready |
| ctl_rdy_i | input | 1 | Live controller ready |
| ecc_rdy_i | input | 1 | Live ECC ready |
| err_det_i | input | 1 | Live errors detected |
| corr_cnt_i | input | 2 | Corrected symbols minus one |
| dec_fail_i | input | 1 | Live decoder failure |
| cfg_o | output | 4 | Interface configuration |
| timing_o | output | 26 | Bus timing word |
| ce_normal_o | output | 1 | Controller-driven chip enable |
| core_reset_o | output | 1 | One-cycle core reset pulse |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The embedded properties check the guard on every cycle. A guarded write taken while open always closes the guard, and a guarded write taken while closed never changes the stored registers. Accesses to other addresses never move the guard. The properties also check that status bits are sticky, that a clearing read with no new event leaves status and interrupt low, and that every reset pulse follows a write. The scenarios cover the rest. They check the exact key value and its byte-lane condition, the merge of partial writes into the timing word, that a same-cycle event survives a clearing read, the live-status bit positions, and the read latency with its unmapped-address value.

// File: rtl/nand_regblk_pkg.sv
package nand_regblk_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;

  localparam int OFF_CMD  = 0;
  localparam int OFF_KEY  = 1;
  localparam int OFF_CFG  = 2;
  localparam int OFF_TIM  = 3;
  localparam int OFF_MASK = 4;
  localparam int OFF_STAT = 5;
  localparam int OFF_LIVE = 6;
  localparam int OFF_CE   = 7;

  localparam logic [15:0] UNLOCK_KEY = 16'hA25E;
  localparam logic [7:0]  RESET_CODE = 8'hFF;

  // merge enabled byte lanes of nxt into old
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old,
                                                  input logic [BUS_W-1:0] nxt,
                                                  input logic [LANES-1:0] en);
    logic [BUS_W-1:0] r;
    r = old;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[8*i +: 8] = nxt[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/nand_regblk_lock.sv
module nand_regblk_lock
  import nand_regblk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic hit_key,
  input  logic hit_prot,
  input  logic key_ok,
  output logic open_o
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  open_q <= 1'b0;
    else if (wr_en && hit_key)   open_q <= key_ok;
    else if (wr_en && hit_prot)  open_q <= 1'b0;
  end

  assign open_o = open_q;

  p_guard_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_prot && !hit_key) |=> !open_q);

  p_other_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (hit_key || hit_prot))) |=> (open_q == $past(open_q)));
endmodule

// File: rtl/nand_regblk_irq.sv
module nand_regblk_irq #(
  parameter int N_EVT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             clr_i,
  input  logic             mask_we_i,
  input  logic [N_EVT-1:0] mask_d_i,
  output logic [N_EVT-1:0] stat_o,
  output logic [N_EVT-1:0] mask_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] stat_q, mask_q, hit;

  for (genvar b = 0; b < N_EVT; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_q[b] <= 1'b0;
        mask_q[b] <= 1'b0;
      end else begin
        stat_q[b] <= (stat_q[b] && !clr_i) || evt_i[b];
        if (mask_we_i) mask_q[b] <= mask_d_i[b];
      end
    end
    assign hit[b] = stat_q[b] & mask_q[b];
  end

  assign irq_o  = |hit;
  assign stat_o = stat_q;
  assign mask_o = mask_q;

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (stat_q == '0));

  p_irq_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> !irq_o);
endmodule

// File: rtl/nand_regblk.sv
module nand_regblk
  import nand_regblk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_EVT  = 6,
  parameter int CFG_W  = 4,
  parameter int TIM_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              nand_rdy_i,
  input  logic              ctl_rdy_i,
  input  logic              ecc_rdy_i,
  input  logic              err_det_i,
  input  logic [1:0]        corr_cnt_i,
  input  logic              dec_fail_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [TIM_W-1:0]  timing_o,
  output logic              ce_normal_o,
  output logic              core_reset_o,
  output logic              irq_o
);
  localparam int LIVE_W = 7;

  logic hit_cmd, hit_key, hit_cfg, hit_tim, hit_mask, hit_stat, hit_live, hit_ce;
  logic hit_prot, key_ok, guard_open;
  logic [CFG_W-1:0]  cfg_q;
  logic [TIM_W-1:0]  tim_q;
  logic              ce_q, rst_pulse_q;
  logic [N_EVT-1:0]  stat, mask;
  logic [LIVE_W-1:0] live;
  logic [31:0]       rd_mux;

  assign hit_cmd  = (addr == ADDR_W'(OFF_CMD));
  assign hit_key  = (addr == ADDR_W'(OFF_KEY));
  assign hit_cfg  = (addr == ADDR_W'(OFF_CFG));
  assign hit_tim  = (addr == ADDR_W'(OFF_TIM));
  assign hit_mask = (addr == ADDR_W'(OFF_MASK));
  assign hit_stat = (addr == ADDR_W'(OFF_STAT));
  assign hit_live = (addr == ADDR_W'(OFF_LIVE));
  assign hit_ce   = (addr == ADDR_W'(OFF_CE));
  assign hit_prot = hit_cfg | hit_tim;
  assign key_ok   = (be[1:0] == 2'b11) && (wdata[15:0] == UNLOCK_KEY);

  nand_regblk_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .hit_key  (hit_key),
    .hit_prot (hit_prot),
    .key_ok   (key_ok),
    .open_o   (guard_open)
  );

  nand_regblk_irq #(.N_EVT(N_EVT)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .clr_i     (rd_en && hit_stat),
    .mask_we_i (wr_en && hit_mask && be[0]),
    .mask_d_i  (wdata[N_EVT-1:0]),
    .stat_o    (stat),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  // guarded and plain control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      tim_q       <= '0;
      ce_q        <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      if (wr_en && hit_cfg && guard_open)
        cfg_q <= CFG_W'(lane_merge(32'(cfg_q), wdata, be));
      if (wr_en && hit_tim && guard_open)
        tim_q <= TIM_W'(lane_merge(32'(tim_q), wdata, be));
      if (wr_en && hit_ce && be[0])
        ce_q <= wdata[0];
      rst_pulse_q <= wr_en && hit_cmd && be[0] && (wdata[7:0] == RESET_CODE);
    end
  end

  assign live = {dec_fail_i, corr_cnt_i, err_det_i, ecc_rdy_i, ctl_rdy_i, nand_rdy_i};

  always_comb begin
    rd_mux = '0;
    if (hit_cfg)  rd_mux = 32'(cfg_q);
    if (hit_tim)  rd_mux = 32'(tim_q);
    if (hit_mask) rd_mux = 32'(mask);
    if (hit_stat) rd_mux = 32'(stat);
    if (hit_live) rd_mux = 32'(live);
    if (hit_ce)   rd_mux = 32'(ce_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign cfg_o        = cfg_q;
  assign timing_o     = tim_q;
  assign ce_normal_o  = ce_q;
  assign core_reset_o = rst_pulse_q;

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_prot && !guard_open) |=> ($stable(cfg_q) && $stable(tim_q)));

  p_single_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_prot && guard_open) |=> !guard_open);

  p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_o |-> $past(wr_en));
endmodule

// File: tb/nand_regblk_test.sv
module nand_regblk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [5:0]  evt_i = '0;
  logic        nand_rdy_i = 0, ctl_rdy_i = 0, ecc_rdy_i = 0, err_det_i = 0, dec_fail_i = 0;
  logic [1:0]  corr_cnt_i = '0;
  logic [3:0]  cfg_o;
  logic [25:0] timing_o;
  logic        ce_normal_o, core_reset_o, irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend_rd = 1'b0;

  always #2.5 clk = ~clk;

  nand_regblk uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .be(be),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .evt_i(evt_i),
    .nand_rdy_i(nand_rdy_i), .ctl_rdy_i(ctl_rdy_i), .ecc_rdy_i(ecc_rdy_i),
    .err_det_i(err_det_i), .corr_cnt_i(corr_cnt_i), .dec_fail_i(dec_fail_i),
    .cfg_o(cfg_o), .timing_o(timing_o), .ce_normal_o(ce_normal_o),
    .core_reset_o(core_reset_o), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) pend_rd <= rd_en;
  always @(negedge clk) begin
    if (pend_rd) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12: unexpected read data %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg", 32'(cfg_o), 0);
    check("R1 timing", 32'(timing_o), 0);
    check("R1 irq/ce/rst", {29'b0, irq_o, ce_normal_o, core_reset_o}, 0);
    rd(4'd5, 0, "R1 status");
    rd(4'd4, 0, "R1 mask");
    // R3 guarded write while closed
    wr(4'd2, 32'hF, 4'hF);
    check("R3 cfg locked", 32'(cfg_o), 0);
    // R2 single-shot unlock
    wr(4'd1, 32'hA25E, 4'b0011);
    wr(4'd2, 32'h6, 4'hF);
    check("R2 cfg unlocked write", 32'(cfg_o), 32'h6);
    wr(4'd2, 32'h9, 4'hF);
    check("R2 relocked after one write", 32'(cfg_o), 32'h6);
    rd(4'd2, 32'h6, "R12 cfg readback");
    // R4 other writes keep guard open
    wr(4'd1, 32'hA25E, 4'b0011);
    wr(4'd4, 32'h3F, 4'b0001);
    wr(4'd7, 32'h1, 4'b0001);
    check("R10 ce_normal", 32'(ce_normal_o), 1);
    wr(4'd3, 32'h0012345, 4'hF);
    check("R4 timing after other writes", 32'(timing_o), 32'h0012345);
    // R4 wrong key closes guard
    wr(4'd1, 32'hA25E, 4'b0011);
    wr(4'd1, 32'h1234, 4'b0011);
    wr(4'd3, 32'h3FFFFFF, 4'hF);
    check("R4 wrong key relocks", 32'(timing_o), 32'h0012345);
    // R11 byte lanes
    wr(4'd1, 32'hA25E, 4'b0011);
    wr(4'd3, 32'h3FFFFFF, 4'b0010);
    check("R11 lane merge", 32'(timing_o), 32'h001FF45);
    // R5 R7 R6 events
    pulse(6'h10);
    check("R7 irq on masked event", 32'(irq_o), 1);
    rd(4'd5, 32'h10, "R6 status read");
    check("R6 irq after clear", 32'(irq_o), 0);
    rd(4'd5, 0, "R6 status cleared");
    wr(4'd4, 32'h01, 4'b0001);
    pulse(6'h20);
    check("R7 masked event no irq", 32'(irq_o), 0);
    rd(4'd5, 32'h20, "R5 nand ready bit5");
    // R6 same-cycle event survives clearing read
    pulse(6'h04);
    @(negedge clk);
    addr = 4'd5; rd_en = 1'b1; evt_i = 6'h08;
    exp_q.push_back(32'h04); tag_q.push_back("R6 read with event");
    @(negedge clk);
    rd_en = 1'b0; evt_i = '0;
    rd(4'd5, 32'h08, "R6 same-cycle event kept");
    pulse(6'h01);
    check("R7 wp fault irq", 32'(irq_o), 1);
    rd(4'd5, 32'h01, "R5 wp fault bit0");
    // R8 reset command, and R4 command write keeps guard
    wr(4'd1, 32'hA25E, 4'b0011);
    wr(4'd0, 32'hFF, 4'b0001);
    check("R8 reset pulse high", 32'(core_reset_o), 1);
    @(negedge clk);
    check("R8 reset pulse one cycle", 32'(core_reset_o), 0);
    wr(4'd2, 32'h8, 4'hF);
    check("R4 cmd write keeps guard", 32'(cfg_o), 32'h8);
    wr(4'd0, 32'hFE, 4'b0001);
    check("R8 no pulse other code", 32'(core_reset_o), 0);
    // R9 live status
    nand_rdy_i = 1; ecc_rdy_i = 1; corr_cnt_i = 2'b10; dec_fail_i = 1;
    rd(4'd6, 32'h65, "R9 live status");
    nand_rdy_i = 0; ctl_rdy_i = 1; err_det_i = 1; corr_cnt_i = 2'b01; dec_fail_i = 1'b0; ecc_rdy_i = 0;
    rd(4'd6, 32'h1A, "R9 live status 2");
    // R12 unmapped and mask
    rd(4'd9, 0, "R12 unmapped reads zero");
    rd(4'd4, 32'h01, "R12 mask readback");
    rd(4'd7, 32'h01, "R10 ce readback");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule